// File: doc/BRIEF.md
# Synchronized Multi-Channel Clock Divider

This block derives several divided clocks from one input clock and lines up their edges whenever a synchronization is requested. Each channel has its own divide ratio, coarse phase offset, static hold level and an opt-out flag. Six request sources are merged into one internal hold request:

- an active-low sync pin
- an active-low power-down pin
- a calibration-busy flag
- three software bits: soft sync, soft reset and distribution power-down

While the hold request is present, every channel that has not opted out parks its output at its static level. Once the request clears, a fixed countdown runs. All participating channels then start clocking on the same edge, each one starting from its own phase position.

All configuration sits in a shadow. Values on the staging inputs do nothing until the update strobe is sampled high. This lets software program ratios, phases and the soft sync bit in advance and apply them atomically. The requests from the pins arrive without relation to the clock, so the merged request passes through a two-flop synchronizer before it reaches the countdown. The block's own reset behaves like one more request, so a power-up alignment happens on its own.

Top module: `sync_clk_divider`

## Requirements
- R1: The hold request is raised when any one of these is true: sync_n low, pd_n low, cal_busy high, or the active soft-sync, soft-reset or distribution-power-down bit set.
- R2: While held, each non-excluded output shows its active preset level. This holds from the fourth rising edge after a pin request is asserted, and on every edge after that until release.
- R3: When the last pin-driven request clears, take the first rising edge that samples the cleared request as edge 1. Every non-excluded output keeps its preset through edge 14 and shows its first running value on edge 15.
- R4: The staging inputs have no effect until upd is sampled high, and they are applied at that edge. When a soft-sync clear is applied by an update, the update edge counts as edge 0, and the first running value appears on edge 15 counted from the edge after it.
- R5: A channel with divide code d runs with period N = d+1, except that code 0 means N = 2. In each period the output is high for N - floor(N/2) cycles and then low for floor(N/2) cycles. The output is a registered comparison of a position counter running 0..N-1.
- R6: At release, each position counter starts at the phase code P when P < N, and at 0 otherwise. Channels with equal N and P are therefore identical, and a larger P moves a channel's waveform earlier by P cycles.
- R7: A channel whose active exclude bit is set keeps clocking at its ratio through any hold.
- R8: A request that returns during the release countdown cancels it. The 15-edge latency of R3 is then counted again from the later clear.
- R9: During reset all outputs are 0 and the shadow holds ratio code 0, phase 0, preset 0 and no exclusions. The end of reset acts as a pin clear, with edge 1 being the first rising edge after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sync_n | input | 1 | Active-low sync request pin, asynchronous |
| pd_n | input | 1 | Active-low power-down pin, asynchronous |
| cal_busy | input | 1 | High while calibration is running |
| upd | input | 1 | Copies all staging inputs into the active shadow |
| stg_soft_sync | input | 1 | Staged software sync bit |
| stg_soft_rst | input | 1 | Staged soft reset bit |
| stg_pd_dist | input | 1 | Staged distribution power-down bit |
| stg_excl | input | NCH | Staged per-channel exclude flags |
| stg_preset | input | NCH | Staged per-channel static level |
| stg_div | input | NCH x NW | Staged divide codes |
| stg_phase | input | NCH x NW | Staged phase codes |
| clk_out | output | NCH | Divided clock outputs |

## Verification
Two things can fall in the same cycle: a new hold request and a release countdown that is already under way. The bench provokes this by pulling sync_n low again six edges after a clear. It judges the result by requiring every output to stay at its preset level and to restart exactly 15 edges after the second clear. Shadow updates can also coincide with a request. The bench loads new ratios, phases and exclusions in the cycle a pin request arrives, and checks that the release then uses the new values. Excluded channels are judged by counting their rising edges during the hold window.

// File: rtl/sync_clk_divider.sv
module sync_clk_divider #(
  parameter int NCH = 4,
  parameter int NW  = 5,
  parameter int LAT = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_n,
  input  logic                    pd_n,
  input  logic                    cal_busy,
  input  logic                    upd,
  input  logic                    stg_soft_sync,
  input  logic                    stg_soft_rst,
  input  logic                    stg_pd_dist,
  input  logic [NCH-1:0]          stg_excl,
  input  logic [NCH-1:0]          stg_preset,
  input  logic [NCH-1:0][NW-1:0]  stg_div,
  input  logic [NCH-1:0][NW-1:0]  stg_phase,
  output logic [NCH-1:0]          clk_out
);
  localparam int CW = $clog2(LAT);
  localparam int MW = NW + 1;
  localparam logic [CW-1:0] KREL = CW'(LAT - 4);

  logic                   soft_sync_q, soft_rst_q, pd_dist_q;
  logic [NCH-1:0]         ex_q, pre_q;
  logic [NCH-1:0][NW-1:0] div_q, ph_q;
  logic                   req_raw, s1, req_s, hold;
  logic [CW-1:0]          rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_sync_q <= 1'b0;
      soft_rst_q  <= 1'b0;
      pd_dist_q   <= 1'b0;
      ex_q        <= '0;
      pre_q       <= '0;
      div_q       <= '0;
      ph_q        <= '0;
    end else if (upd) begin
      soft_sync_q <= stg_soft_sync;
      soft_rst_q  <= stg_soft_rst;
      pd_dist_q   <= stg_pd_dist;
      ex_q        <= stg_excl;
      pre_q       <= stg_preset;
      div_q       <= stg_div;
      ph_q        <= stg_phase;
    end
  end

  assign req_raw = !sync_n || !pd_n || cal_busy || soft_sync_q || soft_rst_q || pd_dist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      req_s   <= 1'b1;
      hold    <= 1'b1;
      rel_cnt <= '0;
    end else begin
      s1    <= req_raw;
      req_s <= s1;
      if (req_s) begin
        hold    <= 1'b1;
        rel_cnt <= '0;
      end else if (hold) begin
        if (rel_cnt == KREL) hold <= 1'b0;
        else                 rel_cnt <= rel_cnt + CW'(1);
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [NW-1:0] pos;
    logic [MW-1:0] n, hi, ld;
    logic          o;

    assign n  = (div_q[i] == '0) ? MW'(2) : {1'b0, div_q[i]} + MW'(1);
    assign hi = n - (n >> 1);
    assign ld = ({1'b0, ph_q[i]} < n) ? {1'b0, ph_q[i]} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos <= '0;
        o   <= 1'b0;
      end else if (hold && !ex_q[i]) begin
        pos <= ld[NW-1:0];
        o   <= pre_q[i];
      end else begin
        o   <= ({1'b0, pos} < hi);
        pos <= ({1'b0, pos} >= n - MW'(1)) ? '0 : pos + NW'(1);
      end
    end

    assign clk_out[i] = o;
  end
endmodule

// File: rtl/sync_clk_divider_chk.sv
module sync_clk_divider_chk #(
  parameter int NCH = 4,
  parameter int LAT = 15,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           upd,
  input logic           req_s,
  input logic           hold,
  input logic [CW-1:0]  rel_cnt,
  input logic [NCH-1:0] ex_q,
  input logic [NCH-1:0] pre_q,
  input logic [NCH-1:0] stg_excl,
  input logic [NCH-1:0] clk_out
);
  localparam logic [CW-1:0] KREL = CW'(LAT - 4);

  a_r1_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_s |=> hold);

  a_r3_release_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(rel_cnt) == KREL && !$past(req_s)));

  a_r8_no_release_under_request: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && req_s) |=> hold);

  a_r4_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ex_q == $past(stg_excl));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r2_static_level: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !ex_q[i]) |=> clk_out[i] == $past(pre_q[i]));
  end
endmodule

bind sync_clk_divider sync_clk_divider_chk #(.NCH(NCH), .LAT(LAT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .req_s(req_s), .hold(hold),
  .rel_cnt(rel_cnt), .ex_q(ex_q), .pre_q(pre_q), .stg_excl(stg_excl),
  .clk_out(clk_out)
);

// File: tb/test_sync_clk_divider.sv
module test_sync_clk_divider;
  localparam int NCH = 4;
  localparam int NW  = 5;
  localparam int OFF = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, pd_n = 1'b1, cal_busy = 1'b0, upd = 1'b0;
  logic stg_soft_sync = 1'b0, stg_soft_rst = 1'b0, stg_pd_dist = 1'b0;
  logic [NCH-1:0] stg_excl = '0, stg_preset = '0;
  logic [NCH-1:0][NW-1:0] stg_div = '0, stg_phase = '0;
  logic [NCH-1:0] clk_out;

  int nN[NCH], pP[NCH];
  logic pre[NCH], ex[NCH];
  int vecs = 0, fails = 0;

  always #5 clk = ~clk;

  sync_clk_divider #(.NCH(NCH), .NW(NW), .LAT(OFF)) i_sync_clk_divider (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pd_n(pd_n), .cal_busy(cal_busy),
    .upd(upd), .stg_soft_sync(stg_soft_sync), .stg_soft_rst(stg_soft_rst),
    .stg_pd_dist(stg_pd_dist), .stg_excl(stg_excl), .stg_preset(stg_preset),
    .stg_div(stg_div), .stg_phase(stg_phase), .clk_out(clk_out));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(logic act, logic expv, string tag, int ch, int k);
    vecs++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s ch%0d edge %0d: actual %0b expected %0b", tag, ch, k, act, expv);
    end
  endtask

  function automatic logic model(int i, int k, int off);
    int m;
    if (k < off) return pre[i];
    m = (pP[i] + (k - off)) % nN[i];
    return (m < nN[i] - nN[i] / 2) ? 1'b1 : 1'b0;
  endfunction

  task automatic stage();
    for (int i = 0; i < NCH; i++) begin
      stg_div[i]    = NW'(nN[i] - 1);
      stg_phase[i]  = NW'(pP[i]);
      stg_preset[i] = pre[i];
      stg_excl[i]   = ex[i];
    end
  endtask

  task automatic run_cmp(int k0, int k1, int off, string tag);
    for (int k = k0; k <= k1; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++)
        if (!ex[i]) check(clk_out[i], model(i, k, off), (k < off) ? "R3" : tag, i, k);
    end
  endtask

  task automatic pulse_upd();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic set_src(int s, logic on);
    case (s)
      0: sync_n = !on;
      1: pd_n = !on;
      2: cal_busy = on;
      3: begin stg_soft_sync = on; pulse_upd(); end
      4: begin stg_soft_rst = on; pulse_upd(); end
      default: begin stg_pd_dist = on; pulse_upd(); end
    endcase
  endtask

  task automatic do_hold(int src);
    logic [NCH-1:0] prev;
    int rises[NCH];
    stage();
    set_src(src, 1'b1);
    if (src < 3) pulse_upd();
    prev = clk_out;
    for (int i = 0; i < NCH; i++) rises[i] = 0;
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (ex[i]) begin
          if (clk_out[i] && !prev[i]) rises[i]++;
        end else if (k >= 6) check(clk_out[i], pre[i], "R1 R2", i, k);
      end
      prev = clk_out;
    end
    for (int i = 0; i < NCH; i++)
      if (ex[i]) begin
        vecs++;
        if (rises[i] < 70 / nN[i] - 1) begin
          fails++;
          $display("FAIL R7 ch%0d excluded rises: actual %0d expected >= %0d", i, rises[i], 70 / nN[i] - 1);
        end
      end
    set_src(src, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NCH; i++) begin nN[i] = 2; pP[i] = 0; pre[i] = 1'b0; ex[i] = 1'b0; end

    // R9: reset state and power-up release
    repeat (3) @(negedge clk);
    for (int i = 0; i < NCH; i++) check(clk_out[i], 1'b0, "R9", i, 0);
    rst_n = 1'b1;
    run_cmp(1, 30, OFF, "R9");

    // R3 R5 R6: directed pin release, shared ratios with distinct phases
    nN = '{4, 4, 6, 3}; pP = '{0, 2, 1, 0}; pre = '{1'b0, 1'b1, 1'b0, 1'b1}; ex = '{1'b0, 1'b0, 1'b0, 1'b0};
    do_hold(0);
    run_cmp(1, 40, OFF, "R6");

    // R4: software sync through update strobe, one channel excluded (R7)
    nN = '{5, 8, 2, 7}; pP = '{4, 3, 1, 6}; pre = '{1'b1, 1'b0, 1'b1, 1'b0}; ex = '{1'b0, 1'b0, 1'b0, 1'b1};
    do_hold(3);
    run_cmp(1, 40, OFF, "R4");
    stg_soft_sync = 1'b1;   // R4: staged only, no update
    run_cmp(41, 70, OFF, "R4");
    stg_soft_sync = 1'b0;

    // R8: request returns during countdown
    nN = '{3, 3, 9, 32}; pP = '{0, 1, 8, 31}; pre = '{1'b0, 1'b0, 1'b1, 1'b1}; ex = '{1'b0, 1'b0, 1'b0, 1'b0};
    do_hold(0);
    run_cmp(1, 6, OFF, "R8");
    sync_n = 1'b0;
    run_cmp(1, 3, 99, "R8");
    sync_n = 1'b1;
    run_cmp(1, 45, OFF, "R8");

    // R1 R5 R6 R7: random configurations across all request sources
    for (int it = 0; it < 24; it++) begin
      for (int i = 0; i < NCH; i++) begin
        nN[i]  = 2 + int'($urandom % 31);
        pP[i]  = int'($urandom % nN[i]);
        pre[i] = 1'($urandom);
        ex[i]  = ($urandom % 4) == 0;
      end
      do_hold(int'($urandom % 6));
      run_cmp(1, 50, OFF, "R1 R5");
    end

    summary();
    $finish;
  end
endmodule